// File: doc/BRIEF.md
# Descriptor Ring Controller

This block keeps one table of 32-bit packet buffer descriptors and walks two independent rings through it. The lower part of the table belongs to the transmit ring. The receive ring starts at an index the host programs. A simple host port reads and writes the descriptor words and two control registers. Word-address bits 11:10 decide whether an access goes to the registers or to the table.

Each ring has an engine with its own current-descriptor pointer. The engine reads its current descriptor and polls it until the host has set the ready flag. It then presents the length and flags to the data mover and waits for a completion pulse. On completion it writes the descriptor back with ready cleared and a status byte. Last, it steps to the next index, or returns to the start of its region when the descriptor carries the wrap flag.

The table has a single port. In any cycle the engines are served before the host. A host access that was refused once is served in the following cycle.

Top module: `bd_ring_ctrl`

## Requirements
- R1: After rst_ni is released, both valid outputs are low, tx_idx_o is 0 and rx_idx_o is RX_BASE_RST (0x80). The control register reads 0 and the receive-base register reads 0x80.
- R2: Host word-address bits 11:10 select the target. 00 selects the registers: offset 0 is the control register and offset 1 is the receive base. 01 selects the table, with the index in bits 7:0. 10 and 11 read as 0, and a write to them changes neither registers nor descriptors.
- R3: A descriptor word holds the length or pause value in bits 31:16, ready in bit 15 and wrap in bit 13. In a transmit descriptor, bit 9 marks a control frame. While an engine is active, its length output carries bits 31:16 and tx_ctrl_o carries bit 9.
- R4: An engine asserts its valid output only for a descriptor read with ready = 1. While ready is 0 it keeps polling and reports nothing.
- R5: On a done pulse the engine writes the descriptor back. Bits 31:16 and 14:8 are kept, bit 15 is cleared, and bits 7:0 take the status input sampled with done.
- R6: After write-back, the pointer returns to the region start when the descriptor's wrap bit was 1, and otherwise moves up by one.
- R7: The transmit region starts at index 0 and the receive region starts at the receive-base register.
- R8: Control bit 0 is a soft reset. While it is 1, both engines are idle and each pointer sits at its region start, following any new base value.
- R9: Control bit 1 enables the transmit engine and bit 2 the receive engine. A disabled engine issues no fetches, reports nothing and holds its pointer.
- R10: A host access is acknowledged one cycle after the request when no engine uses the table, and at most two cycles after it under contention. Register accesses are never delayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Host access request, held until acknowledged |
| host_we_i | input | 1 | Host write enable |
| host_addr_i | input | 12 | Host word address |
| host_wdata_i | input | 32 | Host write data |
| host_ack_o | output | 1 | One-cycle acknowledge |
| host_rdata_o | output | 32 | Read data, valid with acknowledge |
| tx_valid_o | output | 1 | Transmit descriptor is active |
| tx_idx_o | output | IDX_W | Transmit pointer |
| tx_len_o | output | 16 | Transmit length or pause value |
| tx_ctrl_o | output | 1 | Transmit control-frame flag |
| tx_done_i | input | 1 | Transmit completion pulse |
| tx_status_i | input | 8 | Transmit status to write back |
| rx_valid_o | output | 1 | Receive descriptor is active |
| rx_idx_o | output | IDX_W | Receive pointer |
| rx_len_o | output | 16 | Receive buffer length |
| rx_done_i | input | 1 | Receive completion pulse |
| rx_status_i | input | 8 | Receive status to write back |

## Verification
The bench drives both rings around their wrap points. A controller that wrapped at a fixed depth, or returned to index 0 for the receive ring, would report the wrong index on the next descriptor. It also leaves the transmit engine polling a descriptor whose ready bit is 0, then arms that descriptor late. A design that ignored ready would report the stale entry early. One that lost the poll would never report it. Write-back words are read back whole, so a set ready bit, lost flag bits or a misplaced status byte all show up. Further cases cover disabling an engine on a ready descriptor, moving the receive base during soft reset, writes to the unused address space, and host latency while both engines poll. These catch a pointer that keeps running, a base that is ignored, an alias into the registers and a host starved by the engines.

// File: rtl/bd_ring_pkg.sv
package bd_ring_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LEN_W  = 16;
  localparam int unsigned STAT_W = 8;

  localparam int unsigned BIT_READY = 15;
  localparam int unsigned BIT_WRAP  = 13;
  localparam int unsigned BIT_CTRL  = 9;

  localparam logic [1:0] SPACE_REG  = 2'b00;
  localparam logic [1:0] SPACE_DESC = 2'b01;

  typedef enum logic [2:0] {
    E_IDLE,
    E_FETCH,
    E_CHECK,
    E_ACTIVE,
    E_WB
  } eng_st_e;
endpackage

// File: rtl/bd_table.sv
module bd_table
  import bd_ring_pkg::*;
#(
  parameter int unsigned NUM_DESC = 256,
  localparam int unsigned IDX_W = $clog2(NUM_DESC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_req_i,
  input  logic              tx_we_i,
  input  logic [IDX_W-1:0]  tx_addr_i,
  input  logic [WORD_W-1:0] tx_wdata_i,
  input  logic              rx_req_i,
  input  logic              rx_we_i,
  input  logic [IDX_W-1:0]  rx_addr_i,
  input  logic [WORD_W-1:0] rx_wdata_i,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic [IDX_W-1:0]  host_addr_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  output logic              tx_gnt_o,
  output logic              rx_gnt_o,
  output logic              host_gnt_o,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [WORD_W-1:0] mem [NUM_DESC];
  logic              host_wait_q;
  logic              acc_en, acc_we;
  logic [IDX_W-1:0]  acc_addr;
  logic [WORD_W-1:0] acc_wdata;

  // engines first, but a host refused once wins the next cycle
  always_comb begin
    host_gnt_o = host_req_i & (host_wait_q | (~tx_req_i & ~rx_req_i));
    tx_gnt_o   = tx_req_i & ~host_gnt_o;
    rx_gnt_o   = rx_req_i & ~host_gnt_o & ~tx_req_i;
    acc_en     = host_gnt_o | tx_gnt_o | rx_gnt_o;
    if (host_gnt_o) begin
      acc_we = host_we_i; acc_addr = host_addr_i; acc_wdata = host_wdata_i;
    end else if (tx_gnt_o) begin
      acc_we = tx_we_i;   acc_addr = tx_addr_i;   acc_wdata = tx_wdata_i;
    end else begin
      acc_we = rx_we_i;   acc_addr = rx_addr_i;   acc_wdata = rx_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) host_wait_q <= 1'b0;
    else         host_wait_q <= host_req_i & ~host_gnt_o;
  end

  always_ff @(posedge clk_i) begin
    if (acc_en) begin
      if (acc_we) mem[acc_addr] <= acc_wdata;
      else        rd_data_o     <= mem[acc_addr];
    end
  end

  assert_one_grant_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_gnt_o, rx_gnt_o, host_gnt_o}));
  assert_host_not_starved_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_req_i && $past(host_req_i) && !$past(host_gnt_o)) |-> host_gnt_o);
endmodule

// File: rtl/bd_engine.sv
module bd_engine
  import bd_ring_pkg::*;
#(
  parameter int unsigned IDX_W     = 8,
  parameter logic [IDX_W-1:0] START_RST = '0,
  parameter bit          CTRL_EN   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              en_i,
  input  logic [IDX_W-1:0]  start_i,
  input  logic              gnt_i,
  input  logic [WORD_W-1:0] rd_data_i,
  input  logic              done_i,
  input  logic [STAT_W-1:0] status_i,
  output logic              req_o,
  output logic              we_o,
  output logic [IDX_W-1:0]  addr_o,
  output logic [WORD_W-1:0] wdata_o,
  output logic              valid_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              ctrl_o,
  output logic [IDX_W-1:0]  idx_o
);
  eng_st_e           st_q;
  logic [IDX_W-1:0]  ptr_q;
  logic [WORD_W-1:0] cur_q;
  logic [STAT_W-1:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= E_IDLE;
      ptr_q  <= START_RST;
      cur_q  <= '0;
      stat_q <= '0;
    end else if (srst_i) begin
      st_q  <= E_IDLE;
      ptr_q <= start_i;
    end else begin
      unique case (st_q)
        E_IDLE:  if (en_i) st_q <= E_FETCH;
        E_FETCH: begin
          if (!en_i)      st_q <= E_IDLE;
          else if (gnt_i) st_q <= E_CHECK;
        end
        E_CHECK: begin
          cur_q <= rd_data_i;
          if (rd_data_i[BIT_READY]) st_q <= E_ACTIVE;
          else                      st_q <= en_i ? E_FETCH : E_IDLE;
        end
        E_ACTIVE: if (done_i) begin
          stat_q <= status_i;
          st_q   <= E_WB;
        end
        E_WB: if (gnt_i) begin
          ptr_q <= cur_q[BIT_WRAP] ? start_i : ptr_q + 1'b1;
          st_q  <= E_FETCH;
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end

  assign req_o   = (st_q == E_FETCH && en_i) || st_q == E_WB;
  assign we_o    = (st_q == E_WB);
  assign addr_o  = ptr_q;
  assign wdata_o = {cur_q[WORD_W-1:LEN_W], 1'b0, cur_q[BIT_READY-1:STAT_W], stat_q};
  assign valid_o = (st_q == E_ACTIVE);
  assign len_o   = cur_q[WORD_W-1:LEN_W];
  assign ctrl_o  = CTRL_EN ? cur_q[BIT_CTRL] : 1'b0;
  assign idx_o   = ptr_q;

  assert_ready_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(rd_data_i[BIT_READY]));
  assert_ptr_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == E_WB && gnt_i && !srst_i) |=>
      (idx_o == ($past(cur_q[BIT_WRAP]) ? $past(start_i) : $past(idx_o) + 1'b1)));
  assert_srst_home_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (idx_o == $past(start_i) && !valid_o));
  assert_no_fetch_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !valid_o && !we_o) |-> !req_o);
endmodule

// File: rtl/bd_ring_ctrl.sv
module bd_ring_ctrl
  import bd_ring_pkg::*;
#(
  parameter int unsigned NUM_DESC    = 256,
  parameter int unsigned RX_BASE_RST = 128,
  localparam int unsigned IDX_W = $clog2(NUM_DESC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic [11:0]       host_addr_i,
  input  logic [31:0]       host_wdata_i,
  output logic              host_ack_o,
  output logic [31:0]       host_rdata_o,
  output logic              tx_valid_o,
  output logic [IDX_W-1:0]  tx_idx_o,
  output logic [15:0]       tx_len_o,
  output logic              tx_ctrl_o,
  input  logic              tx_done_i,
  input  logic [7:0]        tx_status_i,
  output logic              rx_valid_o,
  output logic [IDX_W-1:0]  rx_idx_o,
  output logic [15:0]       rx_len_o,
  input  logic              rx_done_i,
  input  logic [7:0]        rx_status_i
);
  localparam logic [IDX_W-1:0] BASE_RST = IDX_W'(RX_BASE_RST);
  localparam int unsigned MODE_W = 3;

  logic [MODE_W-1:0] mode_q;
  logic [IDX_W-1:0]  base_q;
  logic              ack_q, ack_mem_q;
  logic [31:0]       reg_rd_q;
  logic              srst, tx_en, rx_en;
  logic              sel_reg, sel_desc, host_mem_req, host_go;
  logic              tx_req, tx_we, tx_gnt, rx_req, rx_we, rx_gnt, host_gnt;
  logic [IDX_W-1:0]  tx_addr, rx_addr;
  logic [31:0]       tx_wdata, rx_wdata, tbl_rd;
  logic              rx_ctrl_nc;

  assign srst  = mode_q[0];
  assign tx_en = mode_q[1] & ~srst;
  assign rx_en = mode_q[2] & ~srst;

  assign sel_reg      = (host_addr_i[11:10] == SPACE_REG);
  assign sel_desc     = (host_addr_i[11:10] == SPACE_DESC);
  assign host_mem_req = host_req_i & sel_desc & ~ack_q;
  assign host_go      = host_req_i & ~ack_q & (~sel_desc | host_gnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= '0;
      base_q    <= BASE_RST;
      ack_q     <= 1'b0;
      ack_mem_q <= 1'b0;
      reg_rd_q  <= '0;
    end else begin
      ack_q <= host_go;
      if (host_go) begin
        ack_mem_q <= sel_desc;
        reg_rd_q  <= '0;
        if (sel_reg) begin
          if (host_addr_i[9:0] == 10'd0) begin
            if (host_we_i) mode_q <= host_wdata_i[MODE_W-1:0];
            reg_rd_q <= 32'(mode_q);
          end else if (host_addr_i[9:0] == 10'd1) begin
            if (host_we_i) base_q <= host_wdata_i[IDX_W-1:0];
            reg_rd_q <= 32'(base_q);
          end
        end
      end
    end
  end

  assign host_ack_o   = ack_q;
  assign host_rdata_o = ack_mem_q ? tbl_rd : reg_rd_q;

  bd_table #(.NUM_DESC(NUM_DESC)) i_table (
    .clk_i, .rst_ni,
    .tx_req_i(tx_req), .tx_we_i(tx_we), .tx_addr_i(tx_addr), .tx_wdata_i(tx_wdata),
    .rx_req_i(rx_req), .rx_we_i(rx_we), .rx_addr_i(rx_addr), .rx_wdata_i(rx_wdata),
    .host_req_i(host_mem_req), .host_we_i(host_we_i),
    .host_addr_i(host_addr_i[IDX_W-1:0]), .host_wdata_i(host_wdata_i),
    .tx_gnt_o(tx_gnt), .rx_gnt_o(rx_gnt), .host_gnt_o(host_gnt), .rd_data_o(tbl_rd)
  );

  bd_engine #(.IDX_W(IDX_W), .START_RST('0), .CTRL_EN(1'b1)) i_tx_eng (
    .clk_i, .rst_ni, .srst_i(srst), .en_i(tx_en), .start_i('0),
    .gnt_i(tx_gnt), .rd_data_i(tbl_rd), .done_i(tx_done_i), .status_i(tx_status_i),
    .req_o(tx_req), .we_o(tx_we), .addr_o(tx_addr), .wdata_o(tx_wdata),
    .valid_o(tx_valid_o), .len_o(tx_len_o), .ctrl_o(tx_ctrl_o), .idx_o(tx_idx_o)
  );

  bd_engine #(.IDX_W(IDX_W), .START_RST(BASE_RST), .CTRL_EN(1'b0)) i_rx_eng (
    .clk_i, .rst_ni, .srst_i(srst), .en_i(rx_en), .start_i(base_q),
    .gnt_i(rx_gnt), .rd_data_i(tbl_rd), .done_i(rx_done_i), .status_i(rx_status_i),
    .req_o(rx_req), .we_o(rx_we), .addr_o(rx_addr), .wdata_o(rx_wdata),
    .valid_o(rx_valid_o), .len_o(rx_len_o), .ctrl_o(rx_ctrl_nc), .idx_o(rx_idx_o)
  );

  assert_ack_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_req_i && !host_ack_o && $past(host_req_i) && !$past(host_ack_o)) |=> host_ack_o);
  assert_ack_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ack_o |=> !host_ack_o);
endmodule

// File: tb/test_bd_ring_ctrl.sv
`timescale 1ns/1ps
module test_bd_ring_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        host_ack;
  logic [31:0] host_rdata;
  logic        tx_valid, tx_ctrl, rx_valid;
  logic [7:0]  tx_idx, rx_idx;
  logic [15:0] tx_len, rx_len;
  logic        tx_done = 1'b0, rx_done = 1'b0;
  logic [7:0]  tx_status = '0, rx_status = '0;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [24:0] tx_q[$];
  logic [24:0] rx_q[$];

  always #2 clk = ~clk;

  bd_ring_ctrl i_bd_ring_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .host_req_i(host_req), .host_we_i(host_we), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_ack_o(host_ack), .host_rdata_o(host_rdata),
    .tx_valid_o(tx_valid), .tx_idx_o(tx_idx), .tx_len_o(tx_len), .tx_ctrl_o(tx_ctrl),
    .tx_done_i(tx_done), .tx_status_i(tx_status),
    .rx_valid_o(rx_valid), .rx_idx_o(rx_idx), .rx_len_o(rx_len),
    .rx_done_i(rx_done), .rx_status_i(rx_status)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  // host access; returns read data and cycles to acknowledge
  task automatic host_op(input logic we, input logic [11:0] a, input logic [31:0] d,
                         output logic [31:0] q, output int lat);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    lat = 0;
    forever begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (host_ack) break;
    end
    q = host_rdata;
    host_req = 1'b0; host_we = 1'b0;
    check("R10 ack latency <= 2", (lat <= 2) ? 32'd1 : 32'd0, 32'd1);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] q; int lat;
    host_op(1'b1, a, d, q, lat);
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] q; int lat;
    host_op(1'b0, a, 32'h0, q, lat);
    check(req, q, exp);
  endtask

  function automatic logic [11:0] dsc(input logic [7:0] i);
    return {4'b0100, i};
  endfunction

  task automatic drain(input string req);
    int t = 0;
    while ((tx_q.size() != 0 || rx_q.size() != 0 || tx_valid || rx_valid) && t < 3000) begin
      @(negedge clk); t++;
    end
    check(req, (t < 3000) ? 32'd1 : 32'd0, 32'd1);
  endtask

  // scoreboard monitors: compare {ctrl, idx, len}, then complete with status idx^A5
  initial forever begin
    @(negedge clk);
    if (tx_valid) begin
      if (tx_q.size() == 0) check("R4 unexpected tx descriptor", {7'h0, tx_ctrl, tx_idx, tx_len}, 32'h0);
      else check("R3/R6 tx descriptor", {7'h0, tx_ctrl, tx_idx, tx_len}, {7'h0, tx_q.pop_front()});
      tx_status = tx_idx ^ 8'hA5; tx_done = 1'b1;
      @(negedge clk); tx_done = 1'b0;
    end
  end

  initial forever begin
    @(negedge clk);
    if (rx_valid) begin
      if (rx_q.size() == 0) check("R4 unexpected rx descriptor", {8'h0, rx_idx, rx_len}, 32'h0);
      else check("R7/R6 rx descriptor", {8'h0, rx_idx, rx_len}, {7'h0, rx_q.pop_front()});
      rx_status = rx_idx ^ 8'hA5; rx_done = 1'b1;
      @(negedge clk); rx_done = 1'b0;
    end
  end

  initial begin
    logic [31:0] q; int lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 tx_idx", tx_idx, 32'h0);
    check("R1 rx_idx", rx_idx, 32'h80);
    check("R1 valids", {tx_valid, rx_valid}, 32'h0);
    rd_chk("R1 control reg", 12'h000, 32'h0);
    rd_chk("R1 base reg", 12'h001, 32'h80);
    // R10 idle latency is exactly one cycle
    host_op(1'b0, 12'h001, 32'h0, q, lat);
    check("R10 idle latency", lat, 32'd1);

    // ring contents (R3 format)
    wr(dsc(8'h00), 32'h0015_8000);
    wr(dsc(8'h01), 32'h0043_8200);
    wr(dsc(8'h02), 32'h0025_A000);
    wr(dsc(8'h80), 32'h0012_8000);
    wr(dsc(8'h81), 32'h0011_A000);
    tx_q.push_back({1'b0, 8'h00, 16'h0015});
    tx_q.push_back({1'b1, 8'h01, 16'h0043});
    tx_q.push_back({1'b0, 8'h02, 16'h0025});
    rx_q.push_back({1'b0, 8'h80, 16'h0012});
    rx_q.push_back({1'b0, 8'h81, 16'h0011});
    wr(12'h000, 32'h6);   // R9 both enabled
    drain("R6 rings drained");
    repeat (10) @(negedge clk);
    // R6 wrap, R4 polling a not-ready entry
    check("R6 tx wrapped to 0", tx_idx, 32'h0);
    check("R6 rx wrapped to base", rx_idx, 32'h80);
    check("R4 no report while not ready", {tx_valid, rx_valid}, 32'h0);
    // R5 write-back contents, read while both engines poll (R10 contention)
    rd_chk("R5 tx desc 2 write-back", dsc(8'h02), 32'h0025_20A7);
    rd_chk("R5 tx desc 1 write-back", dsc(8'h01), 32'h0043_02A4);
    rd_chk("R5 rx desc 0x81 write-back", dsc(8'h81), 32'h0011_2024);

    // R4 arm a polled descriptor late
    tx_q.push_back({1'b0, 8'h00, 16'h0045});
    wr(dsc(8'h00), 32'h0045_8000);
    drain("R4 late ready picked up");
    repeat (4) @(negedge clk);
    check("R6 tx step without wrap", tx_idx, 32'h1);

    // R9 disable holds pointer and ignores a ready descriptor
    wr(12'h000, 32'h0);
    wr(dsc(8'h01), 32'h0050_8000);
    repeat (40) @(negedge clk);
    check("R9 tx idle while disabled", tx_valid, 32'h0);
    check("R9 tx pointer held", tx_idx, 32'h1);
    rd_chk("R9 descriptor untouched", dsc(8'h01), 32'h0050_8000);

    // R8 soft reset and R7 programmable base
    wr(12'h000, 32'h1);
    repeat (2) @(negedge clk);
    check("R8 tx home", tx_idx, 32'h0);
    wr(12'h001, 32'h20);
    repeat (2) @(negedge clk);
    check("R8 rx follows new base", rx_idx, 32'h20);
    rd_chk("R7 base readback", 12'h001, 32'h20);
    wr(dsc(8'h20), 32'h0030_A000);
    rx_q.push_back({1'b0, 8'h20, 16'h0030});
    wr(12'h000, 32'h4);
    drain("R7 rx from new base");
    repeat (4) @(negedge clk);
    check("R7 rx wraps to programmed base", rx_idx, 32'h20);
    check("R9 tx stays disabled", tx_idx, 32'h0);

    // R2 unused space
    wr(12'h800, 32'hFFFF_FFFF);
    wr(12'hC01, 32'hFFFF_FFFF);
    rd_chk("R2 control reg unchanged", 12'h000, 32'h4);
    rd_chk("R2 base reg unchanged", 12'h001, 32'h20);
    rd_chk("R2 descriptor 0 unchanged", dsc(8'h00), 32'h0045_00A5);
    rd_chk("R2 unused space reads 0", 12'h800, 32'h0);
    rd_chk("R2 unused space reads 0", 12'hC01, 32'h0);

    finish_run();
  end
endmodule